// File: doc/BRIEF.md
# Interrupt Entry and Reset Sequencer

This block is the control sequencer that moves an 8-bit processor into a handler. It handles three kinds of entry: power-on reset, a non-maskable interrupt and a maskable interrupt. The core tells it when an instruction boundary is reached and supplies the current program counter, stack pointer and status byte. At an accepted boundary the sequencer takes over a byte-wide memory port. It saves the return address and the flags on the stack, fetches a two-byte vector, and hands the core a new PC, stack pointer and status byte. For as long as it owns the port it holds a busy output high, and the core must not fetch while busy is high.

Maskable requests arrive as a bitmask with separate set and clear strobes for each source. The maskable line is the OR of the pending bits. The non-maskable input is a level, and the block detects its rising edge and holds the result in a pending bit. The maskable line is gated by the interrupt-disable flag as it was captured at the previous instruction boundary, not by the flag's present value. While the core reports that it is jammed, no interrupt is entered.

Top module: `ise_intr_entry`

## Requirements
- R1: While and after reset, the block reads 0xFFFC and then 0xFFFD on consecutive cycles. In the second of those cycles it pulses pc_load_o with pc_o = {byte at 0xFFFD, byte at 0xFFFC}, pulses status_load_o with status_o = 0x04 (only the disable flag, bit 2), and pulses jam_clear_o. busy_o stays high until that cycle has passed.
- R2: An entry is accepted in a cycle where boundary_i is high, the block is idle and a service condition holds, and busy_o is high in that same cycle. pc_load_o pulses exactly 7 cycles after the accepting cycle, and busy_o stays high through that cycle and is low in the next one.
- R3: An entry makes exactly three stack writes, in this order: PC bits 15:8, then PC bits 7:0, then the status byte. They go to 0x0100+S, 0x0100+S-1 and 0x0100+S-2, with S taken modulo 256. The stack pointer handed back on sp_o with sp_load_o is S-3 modulo 256.
- R4: The stacked status byte is the sampled status with bit 4 cleared and bit 5 set. The status handed back is the sampled status with bit 2 set.
- R5: The new PC is read little-endian, low byte first. A non-maskable entry uses 0xFFFA/0xFFFB and a maskable entry uses 0xFFFE/0xFFFF.
- R6: When a non-maskable request and an unmasked maskable request are both pending at an accepted boundary, the non-maskable vector is used and the maskable request stays pending.
- R7: A maskable entry occurs only if bit 2 of status_i, as captured at the previous boundary, was 0. The value of bit 2 at the current boundary does not decide it.
- R8: While jammed_i is high, no entry is accepted, and a pending non-maskable request is kept.
- R9: A rising edge on nmi_i sets nmi_pend_o, and accepting a non-maskable entry clears it. Holding nmi_i high causes only one entry.
- R10: Each maskable source has its own pending bit, set by its set strobe and cleared by its clear strobe. If both strobes arrive in the same cycle, the set wins. irq_req_o is high while any bit is set, and an entry does not clear a bit.
- R11: After any entry, the captured disable flag reads 1, so a maskable request still pending is refused at the first boundary after the handler address is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts the reset vector fetch |
| boundary_i | input | 1 | Core is at an instruction boundary |
| jammed_i | input | 1 | Core is stalled; entries are blocked |
| status_i | input | 8 | Current status byte from the core |
| pc_i | input | 16 | Return address to save |
| sp_i | input | 8 | Current stack pointer |
| nmi_i | input | 1 | Non-maskable request level (edge-detected) |
| irq_set_i | input | SRC_N | Per-source set strobes for maskable requests |
| irq_clr_i | input | SRC_N | Per-source clear strobes for maskable requests |
| mem_rdata_i | input | 8 | Read data, valid in the cycle of the read |
| mem_addr_o | output | 16 | Memory address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_wdata_o | output | 8 | Memory write data |
| busy_o | output | 1 | Sequencer owns the port; fetch is blocked |
| pc_load_o | output | 1 | Load pc_o into the core PC |
| pc_o | output | 16 | New program counter |
| status_load_o | output | 1 | Load status_o into the core status |
| status_o | output | 8 | New status byte |
| sp_load_o | output | 1 | Load sp_o into the core stack pointer |
| sp_o | output | 8 | New stack pointer |
| jam_clear_o | output | 1 | Clear the core's jammed state |
| nmi_pend_o | output | 1 | Non-maskable request pending |
| irq_req_o | output | 1 | OR of the maskable pending bits |

## Verification
A non-maskable edge and an unmasked maskable request can both be waiting at the same boundary. The bench sets a maskable bit and raises nmi_i on the same clock and then presents one boundary. It passes only if the non-maskable vector is loaded, the stacked bytes are correct and irq_req_o is still high afterwards. A second collision comes from the disable flag changing at a boundary while a request is waiting. The bench presents status values whose bit 2 differs from the one captured at the previous boundary and checks that the entry decision follows the captured value.

// File: rtl/ise_pkg.sv
package ise_pkg;
  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 8;
  localparam int FLAG_I     = 2;
  localparam int FLAG_BRK   = 4;
  localparam int FLAG_ONE   = 5;
  localparam logic [DATA_W-1:0] STACK_PAGE = 8'h01;

  typedef enum logic [1:0] {
    KIND_RESET = 2'd0,
    KIND_NMI   = 2'd1,
    KIND_IRQ   = 2'd2
  } entry_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_DUM1  = 3'd1,
    ST_DUM2  = 3'd2,
    ST_PSH_H = 3'd3,
    ST_PSH_L = 3'd4,
    ST_PSH_P = 3'd5,
    ST_VEC_L = 3'd6,
    ST_VEC_H = 3'd7
  } entry_state_e;

  function automatic logic [DATA_W-1:0] stacked_status(input logic [DATA_W-1:0] s);
    logic [DATA_W-1:0] r;
    r = s;
    r[FLAG_BRK] = 1'b0;
    r[FLAG_ONE] = 1'b1;
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] entry_status(input logic [DATA_W-1:0] s,
                                                     input entry_kind_e k);
    logic [DATA_W-1:0] r;
    if (k == KIND_RESET) r = '0;
    else                 r = s;
    r[FLAG_I] = 1'b1;
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] vector_addr(input entry_kind_e k);
    case (k)
      KIND_RESET: return 16'hFFFC;
      KIND_NMI:   return 16'hFFFA;
      default:    return 16'hFFFE;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] stack_addr(input logic [DATA_W-1:0] sp);
    return {STACK_PAGE, sp};
  endfunction
endpackage

// File: rtl/ise_irq_bank.sv
module ise_irq_bank #(
  parameter int SRC_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] set_i,
  input  logic [SRC_N-1:0] clr_i,
  output logic [SRC_N-1:0] pend_o,
  output logic             any_o
);
  for (genvar g = 0; g < SRC_N; g++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pend_o[g] <= 1'b0;
      else if (set_i[g]) pend_o[g] <= 1'b1;
      else if (clr_i[g]) pend_o[g] <= 1'b0;
    end
  end

  assign any_o = |pend_o;
endmodule

// File: rtl/ise_nmi_edge.sv
module ise_nmi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_i,
  input  logic take_i,
  output logic rise_o,
  output logic pend_o
);
  logic nmi_q;

  assign rise_o = nmi_i & ~nmi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      nmi_q  <= nmi_i;
      pend_o <= (pend_o & ~take_i) | rise_o;
    end
  end
endmodule

// File: rtl/ise_entry_arbiter.sv
module ise_entry_arbiter
  import ise_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary_i,
  input  logic              idle_i,
  input  logic              jammed_i,
  input  logic              nmi_pend_i,
  input  logic              irq_any_i,
  input  logic [DATA_W-1:0] status_i,
  output logic              take_nmi_o,
  output logic              take_irq_o,
  output logic              i_seen_o
);
  logic window;
  logic take_any;

  assign window     = boundary_i & idle_i & ~jammed_i;
  assign take_any   = window & (nmi_pend_i | (irq_any_i & ~i_seen_o));
  assign take_nmi_o = take_any & nmi_pend_i;
  assign take_irq_o = take_any & ~nmi_pend_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      i_seen_o <= 1'b1;
    else if (take_any)               i_seen_o <= 1'b1;
    else if (boundary_i && idle_i)   i_seen_o <= status_i[FLAG_I];
  end
endmodule

// File: rtl/ise_entry_fsm.sv
module ise_entry_fsm
  import ise_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_nmi_i,
  input  logic              take_irq_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] sp_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              idle_o,
  output logic              push_stat_o,
  output logic              pc_load_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              status_load_o,
  output logic [DATA_W-1:0] status_o,
  output logic              sp_load_o,
  output logic [DATA_W-1:0] sp_o,
  output logic              jam_clear_o
);
  entry_state_e      state_q;
  entry_kind_e       kind_q;
  logic [ADDR_W-1:0] pc_q;
  logic [DATA_W-1:0] sp_q;
  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:0] vlo_q;
  logic              pushing;

  assign pushing = (state_q == ST_PSH_H) || (state_q == ST_PSH_L) || (state_q == ST_PSH_P);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_VEC_L;
      kind_q  <= KIND_RESET;
      pc_q    <= '0;
      sp_q    <= '0;
      stat_q  <= '0;
      vlo_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (take_nmi_i || take_irq_i) begin
            state_q <= ST_DUM1;
            kind_q  <= take_nmi_i ? KIND_NMI : KIND_IRQ;
            pc_q    <= pc_i;
            sp_q    <= sp_i;
            stat_q  <= status_i;
          end
        end
        ST_DUM1:  state_q <= ST_DUM2;
        ST_DUM2:  state_q <= ST_PSH_H;
        ST_PSH_H: state_q <= ST_PSH_L;
        ST_PSH_L: state_q <= ST_PSH_P;
        ST_PSH_P: state_q <= ST_VEC_L;
        ST_VEC_L: begin
          vlo_q   <= mem_rdata_i;
          state_q <= ST_VEC_H;
        end
        default:  state_q <= ST_IDLE;
      endcase
      if (pushing) sp_q <= sp_q - 1'b1;
    end
  end

  always_comb begin
    mem_addr_o    = '0;
    mem_rd_o      = 1'b0;
    mem_wr_o      = 1'b0;
    mem_wdata_o   = '0;
    pc_load_o     = 1'b0;
    pc_o          = '0;
    status_load_o = 1'b0;
    status_o      = '0;
    sp_load_o     = 1'b0;
    sp_o          = '0;
    jam_clear_o   = 1'b0;
    case (state_q)
      ST_PSH_H: begin
        mem_addr_o  = stack_addr(sp_q);
        mem_wr_o    = 1'b1;
        mem_wdata_o = pc_q[ADDR_W-1:DATA_W];
      end
      ST_PSH_L: begin
        mem_addr_o  = stack_addr(sp_q);
        mem_wr_o    = 1'b1;
        mem_wdata_o = pc_q[DATA_W-1:0];
      end
      ST_PSH_P: begin
        mem_addr_o  = stack_addr(sp_q);
        mem_wr_o    = 1'b1;
        mem_wdata_o = stacked_status(stat_q);
      end
      ST_VEC_L: begin
        mem_addr_o = vector_addr(kind_q);
        mem_rd_o   = 1'b1;
      end
      ST_VEC_H: begin
        mem_addr_o    = vector_addr(kind_q) | 16'h0001;
        mem_rd_o      = 1'b1;
        pc_load_o     = 1'b1;
        pc_o          = {mem_rdata_i, vlo_q};
        status_load_o = 1'b1;
        status_o      = entry_status(stat_q, kind_q);
        sp_load_o     = (kind_q != KIND_RESET);
        sp_o          = sp_q;
        jam_clear_o   = (kind_q == KIND_RESET);
      end
      default: ;
    endcase
  end

  assign idle_o      = (state_q == ST_IDLE);
  assign push_stat_o = (state_q == ST_PSH_P);
endmodule

// File: rtl/ise_intr_entry.sv
module ise_intr_entry
  import ise_pkg::*;
#(
  parameter int SRC_N = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary_i,
  input  logic              jammed_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] sp_i,
  input  logic              nmi_i,
  input  logic [SRC_N-1:0]  irq_set_i,
  input  logic [SRC_N-1:0]  irq_clr_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              busy_o,
  output logic              pc_load_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              status_load_o,
  output logic [DATA_W-1:0] status_o,
  output logic              sp_load_o,
  output logic [DATA_W-1:0] sp_o,
  output logic              jam_clear_o,
  output logic              nmi_pend_o,
  output logic              irq_req_o
);
  logic [SRC_N-1:0] irq_bits_w;
  logic             nmi_rise_w;
  logic             take_nmi_w;
  logic             take_irq_w;
  logic             i_seen_w;
  logic             fsm_idle_w;
  logic             push_stat_w;

  ise_irq_bank #(.SRC_N(SRC_N)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (irq_set_i),
    .clr_i  (irq_clr_i),
    .pend_o (irq_bits_w),
    .any_o  (irq_req_o)
  );

  ise_nmi_edge u_nmi (
    .clk    (clk),
    .rst_n  (rst_n),
    .nmi_i  (nmi_i),
    .take_i (take_nmi_w),
    .rise_o (nmi_rise_w),
    .pend_o (nmi_pend_o)
  );

  ise_entry_arbiter u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .boundary_i (boundary_i),
    .idle_i     (fsm_idle_w),
    .jammed_i   (jammed_i),
    .nmi_pend_i (nmi_pend_o),
    .irq_any_i  (irq_req_o),
    .status_i   (status_i),
    .take_nmi_o (take_nmi_w),
    .take_irq_o (take_irq_w),
    .i_seen_o   (i_seen_w)
  );

  ise_entry_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .take_nmi_i    (take_nmi_w),
    .take_irq_i    (take_irq_w),
    .pc_i          (pc_i),
    .sp_i          (sp_i),
    .status_i      (status_i),
    .mem_rdata_i   (mem_rdata_i),
    .mem_addr_o    (mem_addr_o),
    .mem_rd_o      (mem_rd_o),
    .mem_wr_o      (mem_wr_o),
    .mem_wdata_o   (mem_wdata_o),
    .idle_o        (fsm_idle_w),
    .push_stat_o   (push_stat_w),
    .pc_load_o     (pc_load_o),
    .pc_o          (pc_o),
    .status_load_o (status_load_o),
    .status_o      (status_o),
    .sp_load_o     (sp_load_o),
    .sp_o          (sp_o),
    .jam_clear_o   (jam_clear_o)
  );

  assign busy_o = ~fsm_idle_w | take_nmi_w | take_irq_w;
endmodule

// File: rtl/ise_intr_entry_chk.sv
module ise_intr_entry_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        jammed_i,
  input logic        take_nmi,
  input logic        take_irq,
  input logic        nmi_pend,
  input logic        fsm_idle,
  input logic        push_stat,
  input logic [15:0] mem_addr,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [7:0]  mem_wdata,
  input logic        pc_load,
  input logic        status_load,
  input logic [7:0]  status_val
);
  AST_NMI_BEATS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> !nmi_pend); // R6
  AST_NO_ENTRY_JAMMED: assert property (@(posedge clk) disable iff (!rst_n)
    jammed_i |-> !(take_nmi || take_irq)); // R8
  AST_NMI_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi |-> nmi_pend); // R9
  AST_STACK_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> (mem_addr[15:8] == 8'h01)); // R3
  AST_STACK_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && $past(mem_wr)) |-> (mem_addr[7:0] == $past(mem_addr[7:0]) - 8'd1)); // R3
  AST_PUSHED_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    push_stat |-> (mem_wr && !mem_wdata[4] && mem_wdata[5])); // R4
  AST_LOAD_SETS_I: assert property (@(posedge clk) disable iff (!rst_n)
    status_load |-> status_val[2]); // R4
  AST_VECTOR_HIGH_READ: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (mem_rd && mem_addr[0] && $past(mem_rd))); // R5
  AST_IDLE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> fsm_idle); // R2
endmodule

bind ise_intr_entry ise_intr_entry_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .jammed_i    (jammed_i),
  .take_nmi    (take_nmi_w),
  .take_irq    (take_irq_w),
  .nmi_pend    (nmi_pend_o),
  .fsm_idle    (fsm_idle_w),
  .push_stat   (push_stat_w),
  .mem_addr    (mem_addr_o),
  .mem_rd      (mem_rd_o),
  .mem_wr      (mem_wr_o),
  .mem_wdata   (mem_wdata_o),
  .pc_load     (pc_load_o),
  .status_load (status_load_o),
  .status_val  (status_o)
);

// File: tb/ise_intr_entry_tb.sv
module ise_intr_entry_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SRC_N      = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             boundary_i = 1'b0;
  logic             jammed_i = 1'b0;
  logic [7:0]       status_i = 8'h04;
  logic [15:0]      pc_i = 16'h0000;
  logic [7:0]       sp_i = 8'hFF;
  logic             nmi_i = 1'b0;
  logic [SRC_N-1:0] irq_set_i = '0;
  logic [SRC_N-1:0] irq_clr_i = '0;
  logic [7:0]       mem_rdata_i;
  logic [15:0]      mem_addr_o;
  logic             mem_rd_o, mem_wr_o;
  logic [7:0]       mem_wdata_o;
  logic             busy_o, pc_load_o, status_load_o, sp_load_o, jam_clear_o;
  logic [15:0]      pc_o;
  logic [7:0]       status_o, sp_o;
  logic             nmi_pend_o, irq_req_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    case (mem_addr_o)
      16'hFFFA: mem_rdata_i = 8'h34;
      16'hFFFB: mem_rdata_i = 8'h12;
      16'hFFFC: mem_rdata_i = 8'h00;
      16'hFFFD: mem_rdata_i = 8'h80;
      16'hFFFE: mem_rdata_i = 8'hCD;
      16'hFFFF: mem_rdata_i = 8'hAB;
      default:  mem_rdata_i = 8'hEE;
    endcase
  end

  ise_intr_entry #(.SRC_N(SRC_N)) dut_i (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .jammed_i(jammed_i),
    .status_i(status_i), .pc_i(pc_i), .sp_i(sp_i), .nmi_i(nmi_i),
    .irq_set_i(irq_set_i), .irq_clr_i(irq_clr_i), .mem_rdata_i(mem_rdata_i),
    .mem_addr_o(mem_addr_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .mem_wdata_o(mem_wdata_o), .busy_o(busy_o), .pc_load_o(pc_load_o), .pc_o(pc_o),
    .status_load_o(status_load_o), .status_o(status_o), .sp_load_o(sp_load_o),
    .sp_o(sp_o), .jam_clear_o(jam_clear_o), .nmi_pend_o(nmi_pend_o),
    .irq_req_o(irq_req_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // One boundary cycle; returns whether busy_o rose in that cycle (entry accepted)
  task automatic boundary(input logic [7:0] st, output bit took);
    @(negedge clk);
    status_i   = st;
    boundary_i = 1'b1;
    #1 took = busy_o;
    @(negedge clk);
    boundary_i = 1'b0;
  endtask

  // Called at the negedge in cycle 1 after the accepting cycle
  task automatic follow_entry(input string req, input logic [15:0] exp_pc,
                              input logic [15:0] saved_pc, input logic [7:0] s0,
                              input logic [7:0] exp_push_st, input logic [7:0] exp_load_st);
    logic [15:0] wa [3];
    logic [7:0]  wd [3];
    int nw = 0;
    int load_cyc = -1;
    bit busy_gap = 1'b0;
    bit busy_after = 1'b0;
    for (int cyc = 1; cyc <= 9; cyc++) begin
      #1;
      if (mem_wr_o) begin
        if (nw < 3) begin wa[nw] = mem_addr_o; wd[nw] = mem_wdata_o; end
        nw++;
      end
      if (cyc <= 7 && !busy_o) busy_gap = 1'b1;
      if (cyc == 8) busy_after = busy_o;
      if (pc_load_o && load_cyc < 0) begin
        load_cyc = cyc;
        chk(pc_o == exp_pc, {req, " R5 vector"}, pc_o, exp_pc);
        chk(status_o == exp_load_st, {req, " R4 new status"}, status_o, exp_load_st);
        chk(sp_load_o && sp_o == s0 - 8'd3, {req, " R3 new sp"}, sp_o, s0 - 8'd3);
      end
      @(negedge clk);
    end
    chk(load_cyc == 7, {req, " R2 load cycle"}, load_cyc, 7);
    chk(!busy_gap && !busy_after, {req, " R2 busy span"}, {busy_gap, busy_after}, 0);
    chk(nw == 3, {req, " R3 write count"}, nw, 3);
    if (nw == 3) begin
      chk(wa[0] == {8'h01, s0} && wd[0] == saved_pc[15:8], {req, " R3 push pc high"},
          {wa[0], wd[0]}, {8'h01, s0, saved_pc[15:8]});
      chk(wa[1] == {8'h01, s0 - 8'd1} && wd[1] == saved_pc[7:0], {req, " R3 push pc low"},
          {wa[1], wd[1]}, {8'h01, s0 - 8'd1, saved_pc[7:0]});
      chk(wa[2] == {8'h01, s0 - 8'd2} && wd[2] == exp_push_st, {req, " R4 push status"},
          {wa[2], wd[2]}, {8'h01, s0 - 8'd2, exp_push_st});
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(busy_o && mem_rd_o && mem_addr_o == 16'hFFFC, "R1 reset low vector read",
        mem_addr_o, 16'hFFFC);
    chk(!pc_load_o && !nmi_pend_o && !irq_req_o, "R1 reset idle outputs",
        {pc_load_o, nmi_pend_o, irq_req_o}, 0);
    @(negedge clk);
    #1;
    chk(pc_load_o && pc_o == 16'h8000 && mem_addr_o == 16'hFFFD, "R1 reset pc load",
        pc_o, 16'h8000);
    chk(status_load_o && status_o == 8'h04 && jam_clear_o && !sp_load_o,
        "R1 reset status and jam clear", {status_load_o, status_o, jam_clear_o}, {1'b1, 8'h04, 1'b1});
    @(negedge clk);
    #1;
    chk(!busy_o, "R1 busy released", busy_o, 0);
  endtask

  task automatic t_nmi_basic();
    bit took;
    @(negedge clk);
    nmi_i = 1'b1;
    @(negedge clk);
    #1 chk(nmi_pend_o, "R9 edge sets pending", nmi_pend_o, 1);
    pc_i = 16'h2345; sp_i = 8'hFD;
    boundary(8'h11, took);
    chk(took, "R2 nmi accepted", took, 1);
    if (took) follow_entry("nmi", 16'h1234, 16'h2345, 8'hFD, 8'h21, 8'h15);
    chk(!nmi_pend_o, "R9 pending cleared", nmi_pend_o, 0);
    boundary(8'h04, took);
    chk(!took, "R9 held level no second entry", took, 0);
    @(negedge clk);
    nmi_i = 1'b0;
  endtask

  task automatic t_irq_mask();
    bit took;
    @(negedge clk);
    irq_set_i = 4'b0010;
    @(negedge clk);
    irq_set_i = '0;
    #1 chk(irq_req_o, "R10 set raises request", irq_req_o, 1);
    boundary(8'h00, took);
    chk(!took, "R7 refused on captured set flag", took, 0);
    pc_i = 16'h0456; sp_i = 8'h01;
    boundary(8'h04, took);
    chk(took, "R7 taken on captured clear flag", took, 1);
    if (took) follow_entry("irq", 16'hABCD, 16'h0456, 8'h01, 8'h24, 8'h04);
    #1 chk(irq_req_o, "R10 entry leaves request", irq_req_o, 1);
    boundary(8'h00, took);
    chk(!took, "R11 no re-entry after service", took, 0);
    @(negedge clk);
    irq_clr_i = 4'b0010;
    @(negedge clk);
    irq_clr_i = '0;
    #1 chk(!irq_req_o, "R10 clear drops request", irq_req_o, 0);
  endtask

  task automatic t_set_clr();
    @(negedge clk);
    irq_set_i = 4'b1001;
    @(negedge clk);
    irq_set_i = '0;
    irq_clr_i = 4'b0001;
    @(negedge clk);
    irq_clr_i = '0;
    #1 chk(irq_req_o, "R10 other source keeps request", irq_req_o, 1);
    irq_clr_i = 4'b1000;
    @(negedge clk);
    irq_clr_i = '0;
    #1 chk(!irq_req_o, "R10 all clear", irq_req_o, 0);
    irq_set_i = 4'b0100;
    irq_clr_i = 4'b0100;
    @(negedge clk);
    irq_set_i = '0;
    irq_clr_i = '0;
    #1 chk(irq_req_o, "R10 set wins over clear", irq_req_o, 1);
    irq_clr_i = 4'b0100;
    @(negedge clk);
    irq_clr_i = '0;
    #1 chk(!irq_req_o, "R10 cleared after tie", irq_req_o, 0);
  endtask

  task automatic t_prio();
    bit took;
    boundary(8'h00, took);
    chk(!took, "R6 nothing pending", took, 0);
    @(negedge clk);
    irq_set_i = 4'b0001;
    nmi_i = 1'b1;
    @(negedge clk);
    irq_set_i = '0;
    #1 chk(irq_req_o && nmi_pend_o, "R6 both pending", {irq_req_o, nmi_pend_o}, 2'b11);
    pc_i = 16'h7788; sp_i = 8'h80;
    boundary(8'h00, took);
    chk(took, "R6 entry accepted", took, 1);
    if (took) follow_entry("prio", 16'h1234, 16'h7788, 8'h80, 8'h20, 8'h04);
    chk(irq_req_o && !nmi_pend_o, "R6 maskable still pending", {irq_req_o, nmi_pend_o}, 2'b10);
    nmi_i = 1'b0;
    irq_clr_i = 4'b0001;
    @(negedge clk);
    irq_clr_i = '0;
  endtask

  task automatic t_jam();
    bit took;
    @(negedge clk);
    nmi_i = 1'b1;
    jammed_i = 1'b1;
    @(negedge clk);
    boundary(8'hFF, took);
    chk(!took, "R8 jammed blocks entry", took, 0);
    #1 chk(nmi_pend_o, "R8 pending kept while jammed", nmi_pend_o, 1);
    jammed_i = 1'b0;
    pc_i = 16'hC0DE; sp_i = 8'h00;
    boundary(8'hFF, took);
    chk(took, "R8 entry after unjam", took, 1);
    if (took) follow_entry("jam", 16'h1234, 16'hC0DE, 8'h00, 8'hEF, 8'hFF);
    nmi_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired (R2 sequence hung)");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_nmi_basic();
    t_irq_mask();
    t_set_clr();
    t_prio();
    t_jam();
    repeat (3) @(negedge clk);
    report();
    $finish;
  end
endmodule